// File: doc/BRIEF.md
# Five-Wire Cascadable Wiper Port

This block is a synchronous slave port that holds four 6-bit wiper position registers and gives software-free access to them over a framed serial interface. A frame opens when the frame-enable pin rises and closes when it falls. The direction of the frame is taken from a read/write select pin, which is sampled when the frame opens. In a write frame, serial bytes are shifted in on the rising edges of the serial clock. Each byte names its own target wiper, so one frame can update any subset of the wipers in any order. In a read frame, the wiper contents stream out on the cascade output. The port works only while its active-low port-select input is asserted.

When no frame is open, the cascade output repeats the serial data input. Several ports can therefore be chained. During a write frame the cascade output is held low, so a write meant for this port does not reach the next port in the chain. All pins are asynchronous to the system clock. They pass through a two-flop synchronizer and an edge detector, and every action takes place on a system clock edge. The wiper registers drive a flat parallel output.

Top module: `wiper_shift_port`

## Requirements
- R1: While `port_sel_n` is high, frames, serial clocks and data have no effect on the wipers, and `cas_dout` is 0.
- R2: `rw_sel` is sampled when a frame opens (1 = read, 0 = write). Changes on `rw_sel` while the frame is open do not change the direction of that frame.
- R3: In a write frame, one bit of `ser_din` is taken on each rising edge of `ser_clk`, most significant bit first.
- R4: A write byte is committed on the falling edge of the eighth `ser_clk` pulse. Byte bits 7:6 select the wiper and bits 5:0 give its new position. No other wiper changes.
- R5: A write frame may carry 1 to 4 or more bytes addressed in any order. When one frame writes the same wiper twice, the later byte wins.
- R6: While a write frame is open, `cas_dout` is 0. While no frame is open, `cas_dout` follows `ser_din` combinationally.
- R7: In a read frame, `cas_dout` presents the byte {wiper index in bits 7:6, position in bits 5:0}, most significant bit first. The first bit appears when the frame opens, and each falling `ser_clk` edge advances one bit. The bytes are sent for wipers 0, 1, 2, 3 and then wrap to wiper 0. Reading does not change the wipers.
- R8: After reset, all four wipers hold 32. Position 0 is the low end and position 63 is the high end.
- R9: If a frame closes before the eighth rising clock of a byte, the partial byte is discarded. The next frame starts a fresh byte.
- R10: Pins are synchronized with two flops. A commit becomes visible on `wiper_pos` at the third system clock edge after the falling `ser_clk` pin edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; loads mid-scale into all wipers |
| port_sel_n | input | 1 | Active-low port enable |
| frame_en | input | 1 | Frame enable; rising edge opens a frame, falling edge closes it |
| ser_clk | input | 1 | Serial shift clock |
| ser_din | input | 1 | Serial data input |
| rw_sel | input | 1 | Direction select, 1 = read, 0 = write |
| cas_dout | output | 1 | Cascade / read data output |
| wiper_pos | output | 24 | Wiper positions, wiper i at bits [6i+5:6i] |

## Verification
Every pin change reaches the internal logic two system clock edges later, and the resulting register update happens on the third edge. The bench changes inputs just after a falling system clock edge and holds each level for five cycles. It therefore samples `wiper_pos` and `cas_dout` only after the third edge, except in the R10 check, which samples after exactly two edges and then after three. The idle pass-through path is combinational, so it is checked one nanosecond after `ser_din` moves. Read bits are checked five cycles after each falling serial clock. A near-exhaustive sweep writes every position into every wiper.

// File: rtl/wsp_pkg.sv
package wsp_pkg;
   typedef enum logic {
      MODE_WR = 1'b0,
      MODE_RD = 1'b1
   } xfer_mode_e;

   localparam int PIN_SEL   = 0;
   localparam int PIN_FRAME = 1;
   localparam int PIN_SCLK  = 2;
   localparam int PIN_DIN   = 3;
   localparam int PIN_RW    = 4;
   localparam int PIN_COUNT = 5;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
   parameter int WIDTH  = 5,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pin_i,
   output logic [WIDTH-1:0] level_o,
   output logic [WIDTH-1:0] rise_o,
   output logic [WIDTH-1:0] fall_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pin_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];
   logic [WIDTH-1:0] prev_q;

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else if (s == 0) stage_q[s] <= pin_i;
            else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= stage_q[STAGES-1];
   end

   assign level_o = stage_q[STAGES-1];
   assign rise_o  = stage_q[STAGES-1] & ~prev_q;
   assign fall_o  = ~stage_q[STAGES-1] & prev_q;
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank #(
   parameter int NUM_WIPERS = 4,
   parameter int POS_W      = 6,
   parameter int RESET_POS  = 32,
   localparam int SEL_W     = $clog2(NUM_WIPERS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en_i,
   input  logic [SEL_W-1:0]            wr_sel_i,
   input  logic [POS_W-1:0]            wr_pos_i,
   output logic [NUM_WIPERS*POS_W-1:0] wiper_o
);
   generate
      if (RESET_POS < 0 || RESET_POS >= (1 << POS_W)) begin : g_bad_reset
         $error("wiper_bank: RESET_POS out of range");
      end
   endgenerate

   logic [NUM_WIPERS-1:0] hit;

   genvar w;
   generate
      for (w = 0; w < NUM_WIPERS; w++) begin : g_wiper
         logic [POS_W-1:0] pos_q;
         assign hit[w] = wr_en_i && (wr_sel_i == SEL_W'(w));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      pos_q <= POS_W'(RESET_POS);
            else if (hit[w]) pos_q <= wr_pos_i;
         end
         assign wiper_o[w*POS_W +: POS_W] = pos_q;
      end
   endgenerate

   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit)); // R4
   AST_TARGET_UPDATES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> (wiper_o[$past(wr_sel_i)*POS_W +: POS_W] == $past(wr_pos_i))); // R4
endmodule

// File: rtl/shift_engine.sv
module shift_engine
   import wsp_pkg::*;
#(
   parameter int NUM_WIPERS = 4,
   parameter int POS_W      = 6,
   localparam int SEL_W     = $clog2(NUM_WIPERS),
   localparam int BYTE_W    = SEL_W + POS_W,
   localparam int CNT_W     = $clog2(BYTE_W + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        sel_ok_i,
   input  logic                        frame_rise_i,
   input  logic                        frame_fall_i,
   input  logic                        sclk_rise_i,
   input  logic                        sclk_fall_i,
   input  logic                        din_i,
   input  logic                        rw_i,
   input  logic [NUM_WIPERS*POS_W-1:0] wiper_i,
   output logic                        wr_en_o,
   output logic [SEL_W-1:0]            wr_sel_o,
   output logic [POS_W-1:0]            wr_pos_o,
   output logic                        active_o,
   output logic                        rd_mode_o,
   output logic                        rd_bit_o
);
   generate
      if ((1 << SEL_W) != NUM_WIPERS) begin : g_bad_count
         $error("shift_engine: NUM_WIPERS must be a power of two");
      end
   endgenerate

   logic              active_q;
   xfer_mode_e        mode_q;
   logic [BYTE_W-1:0] wsh_q, rsh_q;
   logic [CNT_W-1:0]  wcnt_q, rcnt_q;
   logic [SEL_W-1:0]  ridx_q;

   function automatic logic [BYTE_W-1:0] read_byte(
      input logic [SEL_W-1:0] idx, input logic [NUM_WIPERS*POS_W-1:0] flat);
      return {idx, flat[idx*POS_W +: POS_W]};
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         mode_q   <= MODE_WR;
         wsh_q    <= '0;
         rsh_q    <= '0;
         wcnt_q   <= '0;
         rcnt_q   <= '0;
         ridx_q   <= '0;
      end else if (!sel_ok_i) begin
         active_q <= 1'b0;
         wcnt_q   <= '0;
      end else if (frame_rise_i) begin
         active_q <= 1'b1;
         mode_q   <= xfer_mode_e'(rw_i);
         wcnt_q   <= '0;
         rcnt_q   <= '0;
         ridx_q   <= SEL_W'(1);
         rsh_q    <= read_byte('0, wiper_i);
      end else if (frame_fall_i) begin
         active_q <= 1'b0;
         wcnt_q   <= '0;
      end else if (active_q && mode_q == MODE_WR) begin
         if (sclk_rise_i && wcnt_q != CNT_W'(BYTE_W)) begin
            wsh_q  <= {wsh_q[BYTE_W-2:0], din_i};
            wcnt_q <= wcnt_q + 1'b1;
         end else if (sclk_fall_i && wcnt_q == CNT_W'(BYTE_W)) begin
            wcnt_q <= '0;
         end
      end else if (active_q && sclk_fall_i) begin
         if (rcnt_q == CNT_W'(BYTE_W-1)) begin
            rsh_q  <= read_byte(ridx_q, wiper_i);
            ridx_q <= ridx_q + 1'b1;
            rcnt_q <= '0;
         end else begin
            rsh_q  <= {rsh_q[BYTE_W-2:0], 1'b0};
            rcnt_q <= rcnt_q + 1'b1;
         end
      end
   end

   assign wr_en_o   = sel_ok_i && active_q && (mode_q == MODE_WR) && !frame_fall_i
                      && sclk_fall_i && (wcnt_q == CNT_W'(BYTE_W));
   assign wr_sel_o  = wsh_q[BYTE_W-1 -: SEL_W];
   assign wr_pos_o  = wsh_q[POS_W-1:0];
   assign active_o  = active_q;
   assign rd_mode_o = (mode_q == MODE_RD);
   assign rd_bit_o  = rsh_q[BYTE_W-1];

   AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_ok_i |=> !active_q); // R1
   AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && $past(active_q)) |-> $stable(mode_q)); // R2
   AST_WCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      wcnt_q <= CNT_W'(BYTE_W)); // R3
   AST_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && mode_q == MODE_RD) |=> $stable(wiper_i)); // R7
   AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      !active_q |=> $stable(wiper_i)); // R9
endmodule

// File: rtl/wiper_shift_port.sv
module wiper_shift_port
   import wsp_pkg::*;
#(
   parameter int NUM_WIPERS  = 4,
   parameter int POS_W       = 6,
   parameter int RESET_POS   = 32,
   parameter int SYNC_STAGES = 2,
   localparam int SEL_W      = $clog2(NUM_WIPERS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        port_sel_n,
   input  logic                        frame_en,
   input  logic                        ser_clk,
   input  logic                        ser_din,
   input  logic                        rw_sel,
   output logic                        cas_dout,
   output logic [NUM_WIPERS*POS_W-1:0] wiper_pos
);
   logic [PIN_COUNT-1:0] pins, lvl, rise, fall;
   logic                 wr_en, active, rd_mode, rd_bit;
   logic [SEL_W-1:0]     wr_sel;
   logic [POS_W-1:0]     wr_pos;

   always_comb begin
      pins            = '0;
      pins[PIN_SEL]   = port_sel_n;
      pins[PIN_FRAME] = frame_en;
      pins[PIN_SCLK]  = ser_clk;
      pins[PIN_DIN]   = ser_din;
      pins[PIN_RW]    = rw_sel;
   end

   pin_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(pins),
      .level_o(lvl), .rise_o(rise), .fall_o(fall));

   shift_engine #(.NUM_WIPERS(NUM_WIPERS), .POS_W(POS_W)) i_engine (
      .clk(clk), .rst_n(rst_n),
      .sel_ok_i(!lvl[PIN_SEL]),
      .frame_rise_i(rise[PIN_FRAME]), .frame_fall_i(fall[PIN_FRAME]),
      .sclk_rise_i(rise[PIN_SCLK]), .sclk_fall_i(fall[PIN_SCLK]),
      .din_i(lvl[PIN_DIN]), .rw_i(lvl[PIN_RW]),
      .wiper_i(wiper_pos),
      .wr_en_o(wr_en), .wr_sel_o(wr_sel), .wr_pos_o(wr_pos),
      .active_o(active), .rd_mode_o(rd_mode), .rd_bit_o(rd_bit));

   wiper_bank #(.NUM_WIPERS(NUM_WIPERS), .POS_W(POS_W), .RESET_POS(RESET_POS)) i_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_pos_i(wr_pos),
      .wiper_o(wiper_pos));

   always_comb begin
      if (lvl[PIN_SEL])  cas_dout = 1'b0;
      else if (!active)  cas_dout = ser_din;
      else if (rd_mode)  cas_dout = rd_bit;
      else               cas_dout = 1'b0;
   end

   AST_WRITE_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !rd_mode) |-> !cas_dout); // R6
endmodule

// File: tb/test_wiper_shift_port.sv
module test_wiper_shift_port;
   localparam int HOLD = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        port_sel_n = 1'b0;
   logic        frame_en = 1'b0;
   logic        ser_clk = 1'b0;
   logic        ser_din = 1'b0;
   logic        rw_sel = 1'b0;
   logic        cas_dout;
   logic [23:0] wiper_pos;

   int tests = 0;
   int fails = 0;
   bit done = 0;
   logic [5:0] model [4];

   always #4 clk = ~clk;

   wiper_shift_port i_wiper_shift_port (
      .clk(clk), .rst_n(rst_n), .port_sel_n(port_sel_n), .frame_en(frame_en),
      .ser_clk(ser_clk), .ser_din(ser_din), .rw_sel(rw_sel),
      .cas_dout(cas_dout), .wiper_pos(wiper_pos));

   function automatic logic [23:0] model_flat();
      return {model[3], model[2], model[1], model[0]};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
      tests++;
      if (act !== exp_v) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
      end
   endtask

   task automatic hold();
      repeat (HOLD) @(negedge clk);
   endtask

   task automatic frame_open(input logic rd);
      rw_sel = rd; hold();
      frame_en = 1'b1; hold();
   endtask

   task automatic frame_close();
      frame_en = 1'b0; hold();
   endtask

   task automatic send_bit(input logic b);
      ser_din = b; hold();
      ser_clk = 1'b1; hold();
      ser_clk = 1'b0; hold();
   endtask

   task automatic send_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
   endtask

   task automatic write_one(input logic [7:0] b);
      send_byte(b);
      model[b[7:6]] = b[5:0];
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) model[i] = 6'd32;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      hold();

      // R8: mid-scale after reset
      check("R8 reset value", wiper_pos, model_flat());
      // R6: idle pass-through
      ser_din = 1'b1; #1;
      check("R6 idle pass high", cas_dout, 1'b1);
      @(negedge clk); ser_din = 1'b0; #1;
      check("R6 idle pass low", cas_dout, 1'b0);
      hold();

      // R3/R4: sweep every position into every wiper
      for (int w = 0; w < 4; w++) begin
         for (int p = 0; p < 64; p++) begin
            frame_open(1'b0);
            write_one({w[1:0], p[5:0]});
            frame_close();
            check("R3 R4 sweep", wiper_pos, model_flat());
         end
      end
      // R8: end points
      check("R8 high end", model[3], 6'd63);

      // R5: four bytes out of order in one frame
      frame_open(1'b0);
      write_one(8'hC5); write_one(8'h4A); write_one(8'h13); write_one(8'hAE);
      frame_close();
      check("R5 four bytes", wiper_pos, model_flat());
      // R5: same wiper twice, later wins
      frame_open(1'b0);
      write_one(8'h41); write_one(8'h7C);
      frame_close();
      check("R5 last wins", wiper_pos, model_flat());

      // R6: muted during write frame
      frame_open(1'b0);
      ser_din = 1'b1; hold();
      check("R6 write mute high din", cas_dout, 1'b0);
      send_bit(1'b1);
      check("R6 write mute mid byte", cas_dout, 1'b0);
      frame_close();
      // R9: partial byte discarded (frame above carried one bit)
      check("R9 partial one bit", wiper_pos, model_flat());
      frame_open(1'b0);
      for (int i = 0; i < 7; i++) send_bit(1'b1);
      frame_close();
      check("R9 partial seven bits", wiper_pos, model_flat());
      frame_open(1'b0);
      write_one(8'h09);
      frame_close();
      check("R9 fresh byte after abort", wiper_pos, model_flat());

      // R2: rw change during write frame ignored
      frame_open(1'b0);
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
      rw_sel = 1'b1;
      send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
      model[2] = 6'h36;
      check("R2 write stays muted", cas_dout, 1'b0);
      frame_close();
      check("R2 write committed", wiper_pos, model_flat());

      // R10: commit latency
      frame_open(1'b0);
      for (int i = 7; i >= 1; i--) send_bit(i == 7 || i == 5);
      ser_din = 1'b1; hold();
      ser_clk = 1'b1; hold();
      ser_clk = 1'b0;
      repeat (2) @(negedge clk);
      check("R10 not before third edge", wiper_pos, model_flat());
      @(negedge clk);
      model[2] = 6'h21;
      check("R10 at third edge", wiper_pos, model_flat());
      hold();
      frame_close();

      // R7: read five bytes with wrap; R2: rw flips mid-frame
      frame_open(1'b1);
      for (int n = 0; n < 5; n++) begin
         logic [7:0] eb;
         eb = {2'(n % 4), model[n % 4]};
         if (n == 2) rw_sel = 1'b0;
         for (int k = 7; k >= 0; k--) begin
            check((n >= 2) ? "R2 R7 read after rw flip" : "R7 read bit", cas_dout, eb[k]);
            ser_din = ~ser_din;
            ser_clk = 1'b1; hold();
            ser_clk = 1'b0; hold();
         end
      end
      frame_close();
      check("R7 read keeps wipers", wiper_pos, model_flat());

      // R1: deselected port ignores a write frame
      port_sel_n = 1'b1; hold();
      frame_open(1'b0);
      send_byte(8'h3F);
      frame_close();
      check("R1 deselected no write", wiper_pos, model_flat());
      ser_din = 1'b1; hold();
      check("R1 deselected output low", cas_dout, 1'b0);
      port_sel_n = 1'b0; ser_din = 1'b0; hold();
      frame_open(1'b0);
      write_one(8'h3F);
      frame_close();
      check("R1 reselected write", wiper_pos, model_flat());

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule